// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer

This block writes an image into a one-time-programmable memory, one word at a time. On a start pulse it turns on the program-voltage enable and walks the address space from zero to the last word. For each word it first reads the memory. If any bit the image needs as 1 already holds 0, the word can never be written, and the run stops at once with that address reported. Otherwise the block drives the image word onto the bidirectional data bus and lowers chip enable for one fixed-width program pulse. It then releases the bus and reads the word back with output enable. It repeats pulse and read-back until the word matches or the pulse limit is used up.

After the last word, the block reads the whole array twice and compares every word with the image. Done or fail is raised and held, together with the failing address, until the next start. Every wait is given in microseconds and turned into clock cycles through a clock-frequency parameter. The image source is a plain lookup: the block presents an address and samples the returned word several cycles later.

Top module: `progseq_top`

## Requirements
- R1: After reset and whenever idle: done and fail low, chip enable and output enable high (inactive), program-voltage enable low, data bus released (high impedance).
- R2: Each program pulse holds chip enable low for exactly CLK_MHZ*PULSE_US cycles (50 us by default, inside the 45 to 55 us window).
- R3: Address and write data are stable for at least CLK_MHZ*SETUP_US cycles before chip enable falls. Data stays driven for at least as long after chip enable rises. The address does not move while chip enable is low, and program voltage is on during every pulse.
- R4: Chip enable and output enable are never low together. Output enable falls only after the block has released the data bus for at least CLK_MHZ*SETUP_US cycles.
- R5: Each word starts with a pulse count of zero. Every pulse is followed by a read-back, and a matching read-back moves on to the next address. On a good run the memory ends equal to the image, and each word gets exactly as many pulses as it needs.
- R6: A word still mismatching after its MAX_PULSES-th pulse (25 by default) ends the run with fail and that address. A word that matches on exactly the 25th pulse passes.
- R7: A word whose memory holds 0 where the image holds 1 is detected by a read before any pulse. It ends the run with fail and its address, and gets zero pulses.
- R8: After the last word, the whole array is read and compared twice: 2 x 2^ADDR_W reads. A mismatch in either pass ends the run with fail and the mismatching address.
- R9: done and fail stay set after the run ends, fail_addr keeps its value, and program-voltage enable drops. Both flags are cleared by the next start.
- R10: done and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| done | output | 1 | Sticky: every word programmed and both check passes clean |
| fail | output | 1 | Sticky: run aborted |
| fail_addr | output | ADDR_W | Address that caused the abort |
| img_addr | output | ADDR_W | Address presented to the image source |
| img_data | input | DATA_W | Image word for img_addr |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data: driven for program, released for read |
| mem_ce_n | output | 1 | Chip enable, active low (program pulse) |
| mem_oe_n | output | 1 | Output enable, active low (read) |
| mem_vpp_en | output | 1 | Program-voltage enable |

## Verification
A wrong phase or a miscounted timer shows up at the memory pins within one phase as a wrong pulse width or a broken setup or hold window. The bench counts each such error cycle by cycle as the run goes. A wrong pulse counter or address counter shows up as a word pulsed too often or too rarely, or skipped. This is seen in the per-address pulse tally and in the final memory contents as soon as the run ends. A wrong compare or a wrong pass count changes the outcome (done against fail), the reported address, or the total number of read strobes.

// File: rtl/progseq_pkg.sv
package progseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_VPP, S_ADDR, S_PRE_RD, S_PRE_OFF, S_DRV, S_PULSE, S_HOLD,
    S_REL, S_VFY_RD, S_VFY_OFF, S_CHK_ADDR, S_CHK_RD, S_CHK_OFF
  } seq_state_t;

  function automatic int us_to_cycles(input int mhz, input int us);
    return (mhz * us < 1) ? 1 : mhz * us;
  endfunction

endpackage

// File: rtl/progseq_timer.sv
module progseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= len - W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(len) - W'(1)));  // R2

endmodule

// File: rtl/progseq_cmp.sv
module progseq_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] rd,
  input  logic [DATA_W-1:0] want,
  output logic              match,
  output logic              stuck
);

  logic [DATA_W-1:0] lost;

  // a bit is lost when the image asks for 1 but the cell already reads 0
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign lost[b] = want[b] & ~rd[b];
  end

  assign match = (rd == want);
  assign stuck = |lost;

endmodule

// File: rtl/progseq_top.sv
module progseq_top
  import progseq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int CLK_MHZ    = 100,
  parameter int PULSE_US   = 50,
  parameter int SETUP_US   = 2,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [DATA_W-1:0] img_data,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_vpp_en
);

  localparam int T_SET = us_to_cycles(CLK_MHZ, SETUP_US);
  localparam int T_PW  = us_to_cycles(CLK_MHZ, PULSE_US);
  localparam int TW    = $clog2(T_PW + 1);
  localparam int PW_W  = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  seq_state_t        st_q, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [PW_W-1:0]   pulses_q;
  logic              pass_q, vok_q;
  logic              dq_oe_q;
  logic [DATA_W-1:0] dq_out_q;
  logic              tz, ld, cmp_match, cmp_stuck, at_limit;
  logic [TW-1:0]     nlen;

  assign mem_dq   = dq_oe_q ? dq_out_q : {DATA_W{1'bz}};
  assign mem_addr = addr_q;
  assign img_addr = addr_q;
  assign at_limit = (pulses_q == PW_W'(MAX_PULSES));

  progseq_cmp #(.DATA_W(DATA_W)) u_cmp (
    .rd(mem_dq), .want(img_data), .match(cmp_match), .stuck(cmp_stuck)
  );

  progseq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(ld), .len(nlen), .zero(tz)
  );

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      S_IDLE:     if (start) nxt = S_VPP;
      S_VPP:      if (tz) nxt = S_ADDR;
      S_ADDR:     if (tz) nxt = S_PRE_RD;
      S_PRE_RD:   if (tz) nxt = cmp_stuck ? S_IDLE : S_PRE_OFF;
      S_PRE_OFF:  if (tz) nxt = S_DRV;
      S_DRV:      if (tz) nxt = S_PULSE;
      S_PULSE:    if (tz) nxt = S_HOLD;
      S_HOLD:     if (tz) nxt = S_REL;
      S_REL:      if (tz) nxt = S_VFY_RD;
      S_VFY_RD:   if (tz) nxt = (!cmp_match && at_limit) ? S_IDLE : S_VFY_OFF;
      S_VFY_OFF:  if (tz) nxt = !vok_q ? S_DRV : ((addr_q == LAST) ? S_CHK_ADDR : S_ADDR);
      S_CHK_ADDR: if (tz) nxt = S_CHK_RD;
      S_CHK_RD:   if (tz) nxt = cmp_match ? S_CHK_OFF : S_IDLE;
      S_CHK_OFF:  if (tz) nxt = (addr_q == LAST && pass_q) ? S_IDLE : S_CHK_ADDR;
      default:    nxt = S_IDLE;
    endcase
  end

  assign ld   = (nxt != st_q);
  assign nlen = (nxt == S_PULSE) ? TW'(T_PW) : TW'(T_SET);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      addr_q     <= '0;
      pulses_q   <= '0;
      pass_q     <= 1'b0;
      vok_q      <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_addr  <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_vpp_en <= 1'b0;
      dq_oe_q    <= 1'b0;
      dq_out_q   <= '0;
    end else begin
      st_q       <= nxt;
      mem_ce_n   <= (nxt != S_PULSE);
      mem_oe_n   <= !(nxt == S_PRE_RD || nxt == S_VFY_RD || nxt == S_CHK_RD);
      mem_vpp_en <= (nxt != S_IDLE);
      dq_oe_q    <= (nxt == S_DRV || nxt == S_PULSE || nxt == S_HOLD);
      if (nxt == S_DRV && st_q != S_DRV) dq_out_q <= img_data;
      unique case (st_q)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          fail     <= 1'b0;
          addr_q   <= '0;
          pulses_q <= '0;
          pass_q   <= 1'b0;
        end
        S_PRE_RD: if (tz && cmp_stuck) begin
          fail      <= 1'b1;
          fail_addr <= addr_q;
        end
        S_PULSE: if (tz) pulses_q <= pulses_q + PW_W'(1);
        S_VFY_RD: if (tz) begin
          vok_q <= cmp_match;
          if (!cmp_match && at_limit) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
          end
        end
        S_VFY_OFF: if (tz && vok_q) begin
          pulses_q <= '0;
          addr_q   <= addr_q + ADDR_W'(1);
        end
        S_CHK_RD: if (tz && !cmp_match) begin
          fail      <= 1'b1;
          fail_addr <= addr_q;
        end
        S_CHK_OFF: if (tz) begin
          addr_q <= addr_q + ADDR_W'(1);
          if (addr_q == LAST) begin
            if (pass_q) done   <= 1'b1;
            else        pass_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE) |-> (mem_ce_n && mem_oe_n && !mem_vpp_en && !dq_oe_q));  // R1
  AST_PULSE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (dq_oe_q && mem_vpp_en));  // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(addr_q));  // R3
  AST_CE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_ce_n && !mem_oe_n));  // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe_q && !mem_oe_n));  // R4
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pulses_q <= PW_W'(MAX_PULSES));  // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));  // R10

endmodule

// File: tb/progseq_top_tb.sv
module progseq_top_tb;

  localparam int AW = 4, DW = 16, NW = 16, MHZ = 1, TS = 2, TPW = 50, MAXP = 25;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic done, fail, ce_n, oe_n, vpp;
  logic [AW-1:0] fail_addr, img_addr, mem_addr;
  logic [DW-1:0] img_data;
  wire  [DW-1:0] dq;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] mem [NW];
  int need [NW];
  int pulses_at [NW];
  int v_setup, v_bus, bad_width, n_reads, n_both;
  int drv_age, since_rise, zage, low_len;
  bit armed, disturb_en, dz;
  logic prev_ce = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] img_of(input int a);
    return DW'((a * 37 + 5) ^ (a << 9) ^ 32'h8000);
  endfunction

  assign img_data = img_of(int'(img_addr));
  assign dq = (!oe_n && ce_n) ? mem[mem_addr] : {DW{1'bz}};

  progseq_top #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .PULSE_US(50),
                .SETUP_US(2), .MAX_PULSES(MAXP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .img_addr(img_addr), .img_data(img_data),
    .mem_addr(mem_addr), .mem_dq(dq), .mem_ce_n(ce_n), .mem_oe_n(oe_n),
    .mem_vpp_en(vpp)
  );

  // memory model and pin-timing monitor
  always @(negedge clk) begin
    if (!rst) begin
      dz = (dq === {DW{1'bz}});
      if (done && fail) n_both++;
      if (oe_n && !dz && dq === prev_dq && mem_addr == prev_addr) drv_age++;
      else drv_age = (oe_n && !dz) ? 1 : 0;
      if (oe_n) zage = dz ? zage + 1 : 0;
      if (!ce_n && !oe_n) v_bus++;
      if (prev_ce && !ce_n) begin
        if (drv_age <= TS) v_setup++;
        if (!vpp) v_setup++;
        low_len = 1;
      end else if (!ce_n) begin
        low_len++;
        if (mem_addr != prev_addr) v_setup++;
      end
      if (!prev_ce && ce_n) begin
        if (low_len != TPW) bad_width++;
        pulses_at[prev_addr]++;
        if (pulses_at[prev_addr] >= need[prev_addr]) mem[prev_addr] = mem[prev_addr] & dq;
        armed = 1'b1;
        since_rise = 0;
      end else if (armed) begin
        since_rise++;
        if (dz || dq !== prev_dq) begin
          if (since_rise < TS) v_setup++;
          armed = 1'b0;
        end
      end
      if (prev_oe && !oe_n) begin
        n_reads++;
        if (zage < TS) v_bus++;
      end
      if (disturb_en && vpp && prev_addr == AW'(NW - 1) && mem_addr == '0) begin
        mem[5] = img_of(5) & (img_of(5) - 16'd1);
        disturb_en = 1'b0;
      end
      prev_ce = ce_n; prev_oe = oe_n; prev_addr = mem_addr; prev_dq = dq;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep();
    for (int a = 0; a < NW; a++) begin
      mem[a] = 16'hFFFF; pulses_at[a] = 0; need[a] = (a % 3) + 1;
    end
    v_setup = 0; v_bus = 0; bad_width = 0; n_reads = 0; disturb_en = 1'b0;
  endtask

  task automatic run();
    bit ended = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check_eq("R9", "flags cleared by start", int'(done) + int'(fail), 0);
    for (int i = 0; i < 60000; i++) begin
      if (done || fail) begin ended = 1'b1; break; end
      @(negedge clk);
    end
    check_eq("WDOG", "run finished", int'(ended), 1);
  endtask

  initial begin
    int sum_need;
    repeat (4) @(negedge clk);
    check_eq("R1", "reset done/fail", int'(done) + int'(fail), 0);
    check_eq("R1", "reset ce_n/oe_n", int'(ce_n) + int'(oe_n), 2);
    check_eq("R1", "reset vpp", int'(vpp), 0);
    check_eq("R1", "reset bus released", int'(dq === {DW{1'bz}}), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "idle vpp", int'(vpp), 0);

    // good run, address 3 needs exactly the limit of pulses
    prep();
    need[3] = MAXP;
    run();
    check_eq("R5", "done", int'(done), 1);
    check_eq("R5", "no fail", int'(fail), 0);
    sum_need = 0;
    for (int a = 0; a < NW; a++) begin
      check_eq("R5", $sformatf("memory word %0d", a), int'(mem[a]), int'(img_of(a)));
      check_eq("R5", $sformatf("pulses at %0d", a), pulses_at[a], need[a]);
      sum_need += need[a];
    end
    check_eq("R6", "limit word passes with 25 pulses", pulses_at[3], MAXP);
    check_eq("R2", "pulse width errors", bad_width, 0);
    check_eq("R3", "setup/hold errors", v_setup, 0);
    check_eq("R4", "bus discipline errors", v_bus, 0);
    check_eq("R8", "read strobes (pre + verify + 2 passes)", n_reads, NW + sum_need + 2 * NW);
    repeat (50) @(negedge clk);
    check_eq("R9", "done sticky", int'(done), 1);
    check_eq("R9", "vpp dropped", int'(vpp), 0);

    // retry limit
    prep();
    need[7] = 30;
    run();
    check_eq("R6", "fail on limit", int'(fail), 1);
    check_eq("R6", "fail_addr", int'(fail_addr), 7);
    check_eq("R6", "pulses at failing word", pulses_at[7], MAXP);
    check_eq("R6", "next word untouched", pulses_at[8], 0);
    repeat (50) @(negedge clk);
    check_eq("R9", "fail sticky", int'(fail), 1);
    check_eq("R9", "fail_addr held", int'(fail_addr), 7);
    check_eq("R9", "vpp dropped after fail", int'(vpp), 0);

    // impossible word
    prep();
    mem[9] = 16'h0000;
    run();
    check_eq("R7", "fail", int'(fail), 1);
    check_eq("R7", "fail_addr", int'(fail_addr), 9);
    check_eq("R7", "no pulse on impossible word", pulses_at[9], 0);
    check_eq("R7", "previous word programmed", pulses_at[8], need[8]);

    // corruption seen in the final check pass
    prep();
    disturb_en = 1'b1;
    run();
    check_eq("R8", "fail in check pass", int'(fail), 1);
    check_eq("R8", "done low", int'(done), 0);
    check_eq("R8", "fail_addr", int'(fail_addr), 5);
    check_eq("R8", "all words were pulsed", pulses_at[15], need[15]);

    check_eq("R10", "done and fail together", n_both, 0);
    check_eq("R4", "bus discipline errors over all runs", v_bus, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule